// File: doc/BRIEF.md
# Violation Status and Mask Register Bank

This block keeps a record of access-permission violations reported for a large set of peripheral indices and turns them into one interrupt line. Each index has a violation pulse input. A pulse sets a sticky status bit for that index. A separate mask bit per index decides whether a set status bit may contribute to the interrupt. The block only records that a violation happened. It does not judge whether an access is allowed, and it stores no detail about the offending access.

Software reaches the status array, the mask array and a control word through a simple register port. Every register is one 32-bit word. Index n is found in word n/32 at bit n%32. Status bits are cleared by writing 1 to them. The control word holds a global enable, with separate start and stop command bits. The interrupt is the registered OR of all unmasked pending status bits, gated by the global enable.

Top module: `vio_status_bank`

## Requirements
- R1: Index n maps to word n/32, bit n%32, in both arrays. Mask word w sits at byte offset 0x000 + 4*w, status word w at 0x400 + 4*w, and the control word at 0xF00. Address bits [1:0] are ignored. Read data appears on `rd_data` one clock after the read request and holds until the next read.
- R2: After reset, every status bit is 0, every valid mask bit is 1, the global enable is 0 and `irq` is 0.
- R3: A pulse on `vio_pulse[n]` sets status bit n. The bit stays set until software clears it.
- R4: A write to a status word clears each bit written as 1. Bits written as 0 keep their value.
- R5: If a pulse on index n arrives in the same cycle as a write that clears bit n, the bit ends up set.
- R6: A write to a mask word stores the written bits. A mask bit of 1 keeps its index out of the interrupt, and a mask bit of 0 lets it through.
- R7: A control write with bit 31 set enables the block, and one with bit 2 set disables it. If both bits are set, the block ends disabled. A control read returns the enable in bit 31 and 0 in every other bit.
- R8: `irq` is 1 exactly when, one clock earlier, the enable was 1 and at least one index had status 1 and mask 0.
- R9: Status and mask bits at positions at or above NUM_IDX read 0 and ignore writes. With the default of 511 indices, the last word holds only bits [30:0]. Addresses outside the three regions read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vio_pulse | input | NUM_IDX | One violation pulse per index |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Aggregated violation interrupt |

## Verification
Several rules are checked by assertions on every cycle:
- the priority of a pulse over a clear in the same cycle;
- the clearing of the bits written as 1, and the stickiness of status bits that are not written;
- the result of the stop and start commands on the enable;
- an `irq` that stays 0 while the block is disabled;
- zero padding in reads of the last word.

The word and bit mapping of every index, including index 510, can only be shown by the bench's scenarios. So can the reset contents, the exact combination of mask and status that raises `irq`, and the reads of addresses outside the three regions. The bench compares all of these against a model built from the requirements, under random stimulus and under directed corner cases.

// File: rtl/vio_bank_pkg.sv
// Package: shared constants, decoded register type and valid-bit helper
// for the violation status bank.
// Assumes: 32-bit register words and byte addressing.
package vio_bank_pkg;

    localparam int unsigned WORD_BITS   = 32;
    localparam int unsigned MASK_BASE   = 32'h000;
    localparam int unsigned STAT_BASE   = 32'h400;
    localparam int unsigned CTRL_OFFSET = 32'hF00;
    localparam int unsigned START_BIT   = 31;
    localparam int unsigned STOP_BIT    = 2;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_STAT = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    // Valid-bit pattern of word w when num_idx indices are implemented.
    function automatic logic [WORD_BITS-1:0] valid_bits(input int unsigned w,
                                                        input int unsigned num_idx);
        logic [WORD_BITS-1:0] v;
        v = '0;
        for (int unsigned b = 0; b < WORD_BITS; b++) begin
            if (w * WORD_BITS + b < num_idx) v[b] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/vio_addr_dec.sv
// Module: vio_addr_dec
// Decodes a byte address into a register region and a word index.
// Assumes: word-aligned registers. The low two address bits are ignored.
// Regions that run past the implemented word count decode as SEL_NONE.
module vio_addr_dec
    import vio_bank_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned WORDS  = 16,
    localparam int unsigned WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o,
    output logic [WIDX_W-1:0] word_o
);

    localparam int unsigned SPAN = WORDS * 4;

    int unsigned aligned;

    // Region and word selection from the aligned address.
    always_comb begin
        aligned = int'({addr_i[ADDR_W-1:2], 2'b00});
        sel_o   = SEL_NONE;
        word_o  = '0;
        if (aligned == CTRL_OFFSET) begin
            sel_o = SEL_CTRL;
        end else if (aligned >= MASK_BASE && aligned < MASK_BASE + SPAN) begin
            sel_o  = SEL_MASK;
            word_o = WIDX_W'((aligned - MASK_BASE) >> 2);
        end else if (aligned >= STAT_BASE && aligned < STAT_BASE + SPAN) begin
            sel_o  = SEL_STAT;
            word_o = WIDX_W'((aligned - STAT_BASE) >> 2);
        end
    end

endmodule

// File: rtl/vio_word_slice.sv
// Module: vio_word_slice
// Holds one word of 32 indices: sticky status bits with write-1-to-clear,
// and mask bits. Reports whether any unmasked status bit is pending.
// Assumes: VALID marks the implemented bits. Bits outside VALID stay 0.
module vio_word_slice #(
    parameter logic [31:0] VALID = 32'hFFFF_FFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] pulse_i,
    input  logic        stat_wr_i,
    input  logic        mask_wr_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] stat_o,
    output logic [31:0] mask_o,
    output logic        pend_o
);

    logic [31:0] stat_q;
    logic [31:0] mask_q;
    logic [31:0] clr;

    // Bits to clear: written as 1 on a status write.
    always_comb clr = stat_wr_i ? wdata_i : '0;

    // Status update: a new pulse overrides a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= ((stat_q & ~clr) | pulse_i) & VALID;
    end

    // Mask update: reset to all masked, replaced on a mask write.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= VALID;
        else if (mask_wr_i) mask_q <= wdata_i & VALID;
    end

    // Pending flag for the interrupt tree.
    always_comb pend_o = |(stat_q & ~mask_q);

    assign stat_o = stat_q;
    assign mask_o = mask_q;

    // R5
    pulse_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pulse_i & VALID)) |=> ((stat_q & $past(pulse_i & VALID)) == $past(pulse_i & VALID)));

    // R4
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr_i |=> ((stat_q & $past(wdata_i & ~pulse_i)) == '0));

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

endmodule

// File: rtl/vio_ctrl_reg.sv
// Module: vio_ctrl_reg
// Global enable register. The start and stop command bits are both
// decoded from one write word, and stop wins when both are set.
// Assumes: a write only acts when wr_i is high.
module vio_ctrl_reg
    import vio_bank_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic [31:0] wdata_i,
    output logic        en_o
);

    logic en_q;

    // Enable update from the start and stop command bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                          en_q <= 1'b0;
        else if (wr_i && wdata_i[STOP_BIT])  en_q <= 1'b0;
        else if (wr_i && wdata_i[START_BIT]) en_q <= 1'b1;
    end

    assign en_o = en_q;

    // R7
    stop_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i[STOP_BIT]) |=> !en_q);

    // R7
    start_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i[START_BIT] && !wdata_i[STOP_BIT]) |=> en_q);

endmodule

// File: rtl/vio_status_bank.sv
// Module: vio_status_bank (top)
// Register bank recording per-index access violations. The status and
// mask words are built from word slices. The interrupt is the registered,
// enable-gated OR of all unmasked pending bits.
// Assumes: NUM_IDX <= 64*32 and ADDR_W >= 12, so that all three regions
// fit the address space.
module vio_status_bank
    import vio_bank_pkg::*;
#(
    parameter int unsigned NUM_IDX = 511,
    parameter int unsigned ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IDX-1:0] vio_pulse,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [31:0]        req_wdata,
    output logic [31:0]        rd_data,
    output logic               irq
);

    localparam int unsigned WORDS  = (NUM_IDX + WORD_BITS - 1) / WORD_BITS;
    localparam int unsigned WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [31:0] LAST_VALID = valid_bits(WORDS - 1, NUM_IDX);

    reg_sel_e                   sel;
    logic [WIDX_W-1:0]          widx;
    logic [WORDS*WORD_BITS-1:0] pulse_pad;
    logic [WORDS-1:0]           pend;
    logic [31:0]                stat_w [WORDS];
    logic [31:0]                mask_w [WORDS];
    logic                       wr_en;
    logic                       rd_en;
    logic                       ctrl_en;
    logic [31:0]                rd_next;
    logic                       irq_q;
    logic [31:0]                rd_q;

    assign wr_en = req_valid && req_write;
    assign rd_en = req_valid && !req_write;

    vio_addr_dec #(
        .ADDR_W(ADDR_W),
        .WORDS (WORDS)
    ) u_dec (
        .addr_i(req_addr),
        .sel_o (sel),
        .word_o(widx)
    );

    // Pad the pulse vector up to a whole number of words.
    always_comb begin
        pulse_pad              = '0;
        pulse_pad[NUM_IDX-1:0] = vio_pulse;
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        localparam logic [31:0] VB = valid_bits(g, NUM_IDX);
        logic hit;
        assign hit = (int'(widx) == g);
        vio_word_slice #(.VALID(VB)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .pulse_i  (pulse_pad[g*WORD_BITS +: WORD_BITS]),
            .stat_wr_i(wr_en && sel == SEL_STAT && hit),
            .mask_wr_i(wr_en && sel == SEL_MASK && hit),
            .wdata_i  (req_wdata),
            .stat_o   (stat_w[g]),
            .mask_o   (mask_w[g]),
            .pend_o   (pend[g])
        );
    end

    vio_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr_en && sel == SEL_CTRL),
        .wdata_i(req_wdata),
        .en_o   (ctrl_en)
    );

    // Read multiplexer over the three regions.
    always_comb begin
        rd_next = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (int'(widx) == w) begin
                if (sel == SEL_STAT) rd_next = stat_w[w];
                if (sel == SEL_MASK) rd_next = mask_w[w];
            end
        end
        if (sel == SEL_CTRL) rd_next[START_BIT] = ctrl_en;
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= rd_next;
    end

    // Registered interrupt, gated by the global enable.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= ctrl_en && (|pend);
    end

    assign rd_data = rd_q;
    assign irq     = irq_q;

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> !irq);

    // R9
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (sel == SEL_STAT || sel == SEL_MASK) && int'(widx) == WORDS - 1)
        |=> ((rd_data & ~LAST_VALID) == '0));

endmodule

// File: tb/vio_status_bank_test.sv
module vio_status_bank_test;

    localparam int unsigned NUM_IDX = 511;
    localparam int unsigned ADDR_W  = 12;
    localparam int unsigned WORDS   = (NUM_IDX + 31) / 32;
    localparam time         CLK_PERIOD = 10ns;
    localparam int          WATCHDOG   = 150000;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [NUM_IDX-1:0] vio_pulse;
    logic               req_valid;
    logic               req_write;
    logic [ADDR_W-1:0]  req_addr;
    logic [31:0]        req_wdata;
    logic [31:0]        rd_data;
    logic               irq;

    logic [NUM_IDX-1:0] stat_m;
    logic [NUM_IDX-1:0] mask_m;
    logic               en_m;
    int                 n_chk  = 0;
    int                 n_fail = 0;
    bit                 done   = 0;

    vio_status_bank #(.NUM_IDX(NUM_IDX), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .vio_pulse(vio_pulse),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data(rd_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] word_of(input logic [NUM_IDX-1:0] v, input int w);
        logic [31:0] r = '0;
        for (int b = 0; b < 32; b++) if (w*32 + b < NUM_IDX) r[b] = v[w*32 + b];
        return r;
    endfunction

    function automatic logic exp_irq();
        return en_m && (|(stat_m & ~mask_m));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One access cycle; pulses may ride along. Model updated after the edge.
    task automatic access(input logic wr, input logic [11:0] addr,
                          input logic [31:0] data, input logic [NUM_IDX-1:0] pul);
        int w;
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = data;
        vio_pulse = pul;
        @(posedge clk);
        w = int'(addr[11:2]);
        if (wr) begin
            if (addr[11:2] == 10'(12'hF00 >> 2)) begin
                if (data[2]) en_m = 1'b0; else if (data[31]) en_m = 1'b1;
            end else if (w >= 256 && w < 256 + WORDS) begin
                for (int b = 0; b < 32; b++)
                    if ((w-256)*32 + b < NUM_IDX && data[b]) stat_m[(w-256)*32 + b] = 1'b0;
            end else if (w < WORDS) begin
                for (int b = 0; b < 32; b++)
                    if (w*32 + b < NUM_IDX) mask_m[w*32 + b] = data[b];
            end
        end
        stat_m = stat_m | pul;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; vio_pulse = '0;
    endtask

    task automatic wr(input logic [11:0] addr, input logic [31:0] data);
        access(1'b1, addr, data, '0);
    endtask

    task automatic rd_check(input string req, input logic [11:0] addr, input logic [31:0] exp);
        access(1'b0, addr, 32'h0, '0);
        check(req, rd_data, exp);
    endtask

    task automatic irq_check(input string req);
        @(posedge clk);
        @(negedge clk);
        check(req, {31'b0, irq}, {31'b0, exp_irq()});
    endtask

    task automatic pulse1(input int idx);
        logic [NUM_IDX-1:0] p = '0;
        p[idx] = 1'b1;
        access(1'b0, 12'h800, 32'h0, p);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; vio_pulse = '0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0;
        stat_m = '0; mask_m = '1; en_m = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        check("R2 irq", {31'b0, irq}, 32'h0);
        rd_check("R2 mask w0", 12'h000, 32'hFFFF_FFFF);
        rd_check("R2 status w0", 12'h400, 32'h0);
        rd_check("R2 ctrl", 12'hF00, 32'h0);
        // R9 padding of last mask word
        rd_check("R9 mask last", 12'h03C, 32'h7FFF_FFFF);

        // R7 start; R6 unmask index 5; R3 pulse
        wr(12'hF00, 32'h8000_0000);
        rd_check("R7 ctrl on", 12'hF00, 32'h8000_0000);
        wr(12'h000, 32'hFFFF_FFDF);
        pulse1(5);
        irq_check("R8 irq raised");
        rd_check("R3 sticky bit5", 12'h400, 32'h0000_0020);
        // R4 writing zero leaves bit
        wr(12'h400, 32'hFFFF_FFDF);
        rd_check("R4 zero write keeps", 12'h400, 32'h0000_0020);
        // R5 clear and pulse together
        access(1'b1, 12'h400, 32'h0000_0020, NUM_IDX'(1) << 5);
        rd_check("R5 pulse wins", 12'h400, 32'h0000_0020);
        wr(12'h400, 32'h0000_0020);
        rd_check("R4 cleared", 12'h400, 32'h0);
        irq_check("R8 irq dropped");
        // R6 masked index does not raise
        pulse1(6);
        irq_check("R6 masked no irq");
        // R1 index 510 mapping
        pulse1(510);
        rd_check("R1 idx510", 12'h43D, 32'h4000_0000);
        // R9 writes above the last index ignored, unmapped region
        wr(12'h03C, 32'hFFFF_FFFF);
        wr(12'h03C, 32'h0000_0000);
        rd_check("R9 mask pad", 12'h03C, 32'h0);
        irq_check("R8 idx510 irq");
        rd_check("R9 unmapped", 12'h800, 32'h0);
        wr(12'h800, 32'hFFFF_FFFF);
        rd_check("R9 unmapped write", 12'h000, word_of(mask_m, 0));
        // R7 stop with both bits, irq gated
        wr(12'hF00, 32'h8000_0004);
        rd_check("R7 stop wins", 12'hF00, 32'h0);
        irq_check("R8 disabled");
        wr(12'hF00, 32'h8000_0000);
        irq_check("R8 re-enabled");

        // Random mix
        for (int it = 0; it < 600; it++) begin
            int op = int'($urandom % 6);
            int w  = int'($urandom % WORDS);
            logic [NUM_IDX-1:0] p = '0;
            if ($urandom % 2) p[$urandom % NUM_IDX] = 1'b1;
            case (op)
                0: access(1'b0, 12'h800, 32'h0, p);
                1: access(1'b1, 12'h400 + 12'(w*4), $urandom, p);
                2: access(1'b1, 12'(w*4), $urandom | $urandom, p);
                3: rd_check("R1 rand status", 12'h400 + 12'(w*4), word_of(stat_m, w));
                4: rd_check("R6 rand mask", 12'(w*4), word_of(mask_m, w));
                default: wr(12'hF00, ($urandom % 4 == 0) ? 32'h4 : 32'h8000_0000);
            endcase
            irq_check("R8 rand irq");
        end

        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule